// File: doc/BRIEF.md
# EDID Memory Port for a Display Data Channel Slave

This block sits between an I2C slave front end and a 256-byte EDID store. The front end turns bus traffic into single-cycle strobes: a pointer load carrying the word address, a byte write carrying data, and a byte read. The block keeps the word address pointer, applies write protection to each 128-byte half on its own, and can fold every slave access into the lower 128 bytes. It also serves bytes for a continuous one-way transmit mode, but only while that mode is enabled.

A local processor port writes and reads any location directly and ignores the protection bits. It is how the EDID image is loaded. Read data and acknowledge pulses are registered. They appear one clock after the strobe that asked for them.

Top module: `ddc_edid_port`

## Requirements
- R1: While `rst_n` is low and after it is released, `ptr_q` is 0x00 and `sl_rvalid`, `sl_ack`, `d1_valid` and `cpu_rvalid` are 0.
- R2: A `sl_load` strobe sets `ptr_q` to `sl_wdata` on the next clock.
- R3: A `sl_rd` strobe returns the byte at the pointer on `sl_rdata`, with `sl_rvalid` high, one clock later. The pointer then advances by one. With lower-only mode off it wraps from 0xFF to 0x00.
- R4: A `sl_wr` to an effective address 0x00–0x7F stores `sl_wdata` only when `cfg_lo_wen` is 1. Otherwise the memory is left unchanged.
- R5: A `sl_wr` to an effective address 0x80–0xFF stores `sl_wdata` only when `cfg_hi_wen` is 1. Otherwise the memory is left unchanged.
- R6: Every `sl_wr`, stored or blocked, raises `sl_ack` for one clock on the next cycle and advances the pointer.
- R7: With `cfg_lo_only` at 1, the effective address is the pointer with bit 7 cleared. The advanced pointer also has bit 7 cleared, so 0x7F is followed by 0x00.
- R8: A `d1_req` with `cfg_d1_en` at 1 returns the byte at the pointer on `d1_data`, with `d1_valid` high, one clock later, and advances the pointer. With `cfg_d1_en` at 0 the request has no effect.
- R9: A `cpu_wr` stores `cpu_wdata` at `cpu_addr` whatever the protection bits are. A `cpu_rd` returns the byte at `cpu_addr` on `cpu_rdata`, with `cpu_rvalid` high, one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lo_wen | input | 1 | Bus writes allowed to lower half |
| cfg_hi_wen | input | 1 | Bus writes allowed to upper half |
| cfg_lo_only | input | 1 | Fold slave accesses into lower half |
| cfg_d1_en | input | 1 | Continuous-transmit mode enable |
| sl_load | input | 1 | Load pointer from sl_wdata |
| sl_wr | input | 1 | Write sl_wdata at pointer |
| sl_rd | input | 1 | Read byte at pointer |
| sl_wdata | input | 8 | Address or data byte from slave front end |
| sl_rdata | output | 8 | Read data for slave |
| sl_rvalid | output | 1 | sl_rdata valid pulse |
| sl_ack | output | 1 | Write acknowledge pulse |
| ptr_q | output | 8 | Current word address pointer |
| d1_req | input | 1 | Request next continuous-transmit byte |
| d1_data | output | 8 | Continuous-transmit byte |
| d1_valid | output | 1 | d1_data valid pulse |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_addr | input | 8 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Processor read data |
| cpu_rvalid | output | 1 | cpu_rdata valid pulse |

## Verification
The assertions assume that the front end raises at most one of `sl_load`, `sl_wr` and `sl_rd` in a cycle. They also assume that a processor write never coincides with a slave write, because the store has a single write port. The bench drives every strobe from a task that raises exactly one of them for exactly one cycle. It loads the EDID image through the processor port before any slave traffic, so the two write sources never overlap.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_WRITE = 3'd2,
    OP_READ  = 3'd3,
    OP_D1    = 3'd4
  } slv_op_e;
endpackage

// File: rtl/ddc_ptr.sv
module ddc_ptr
  import ddc_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lo_only,
  input  slv_op_e       op,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] ptr_q,
  output logic [AW-1:0] eff_addr
);
  logic [AW-1:0] ptr_d;
  logic          step;

  assign step = (op == OP_WRITE) || (op == OP_READ) || (op == OP_D1);

  always_comb begin
    eff_addr = ptr_q;
    if (lo_only) eff_addr[AW-1] = 1'b0;
  end

  always_comb begin
    ptr_d = ptr_q;
    if (op == OP_LOAD) begin
      ptr_d = load_val;
    end else if (step) begin
      ptr_d = eff_addr + 1'b1;
      if (lo_only) ptr_d[AW-1] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ptr_q <= '0;
    else if (step || op == OP_LOAD)  ptr_q <= ptr_d;
  end

  // R2
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LOAD) |=> (ptr_q == $past(load_val)));

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !lo_only) |=> (ptr_q == AW'($past(ptr_q) + 1'b1)));

  // R7
  ptr_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && lo_only) |=> (ptr_q[AW-1] == 1'b0));
endmodule

// File: rtl/ddc_guard.sv
module ddc_guard #(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr,
  input  logic          lo_wen,
  input  logic          hi_wen,
  input  logic          wr_req,
  output logic          wr_ok
);
  logic upper;
  assign upper = addr[AW-1];
  assign wr_ok = wr_req && (upper ? hi_wen : lo_wen);
endmodule

// File: rtl/ddc_mem.sv
module ddc_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re_a,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic          re_b,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re_a) rdata_a <= store[raddr_a];
  end

  always_ff @(posedge clk) begin
    if (re_b) rdata_b <= store[raddr_b];
  end
endmodule

// File: rtl/ddc_edid_port.sv
module ddc_edid_port
  import ddc_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_lo_wen,
  input  logic          cfg_hi_wen,
  input  logic          cfg_lo_only,
  input  logic          cfg_d1_en,
  input  logic          sl_load,
  input  logic          sl_wr,
  input  logic          sl_rd,
  input  logic [DW-1:0] sl_wdata,
  output logic [DW-1:0] sl_rdata,
  output logic          sl_rvalid,
  output logic          sl_ack,
  output logic [AW-1:0] ptr_q,
  input  logic          d1_req,
  output logic [DW-1:0] d1_data,
  output logic          d1_valid,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_rvalid
);
  slv_op_e       op;
  logic [AW-1:0] eff_addr;
  logic          slv_wr_ok;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] port_a_data;
  logic          rd_a;
  logic          sl_rvalid_d, sl_ack_d, d1_valid_d, cpu_rvalid_d;

  always_comb begin
    op = OP_IDLE;
    if (sl_load)                 op = OP_LOAD;
    else if (sl_wr)              op = OP_WRITE;
    else if (sl_rd)              op = OP_READ;
    else if (d1_req && cfg_d1_en) op = OP_D1;
  end

  ddc_ptr #(.AW(AW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .lo_only  (cfg_lo_only),
    .op       (op),
    .load_val (sl_wdata[AW-1:0]),
    .ptr_q    (ptr_q),
    .eff_addr (eff_addr)
  );

  ddc_guard #(.AW(AW)) u_guard (
    .addr   (eff_addr),
    .lo_wen (cfg_lo_wen),
    .hi_wen (cfg_hi_wen),
    .wr_req (op == OP_WRITE),
    .wr_ok  (slv_wr_ok)
  );

  always_comb begin
    mem_we    = cpu_wr | slv_wr_ok;
    mem_waddr = cpu_wr ? cpu_addr  : eff_addr;
    mem_wdata = cpu_wr ? cpu_wdata : sl_wdata;
  end

  assign rd_a = (op == OP_READ) || (op == OP_D1);

  ddc_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .re_a    (rd_a),
    .raddr_a (eff_addr),
    .rdata_a (port_a_data),
    .re_b    (cpu_rd),
    .raddr_b (cpu_addr),
    .rdata_b (cpu_rdata)
  );

  assign sl_rdata = port_a_data;
  assign d1_data  = port_a_data;

  always_comb begin
    sl_rvalid_d  = (op == OP_READ);
    sl_ack_d     = (op == OP_WRITE);
    d1_valid_d   = (op == OP_D1);
    cpu_rvalid_d = cpu_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sl_rvalid  <= 1'b0;
      sl_ack     <= 1'b0;
      d1_valid   <= 1'b0;
      cpu_rvalid <= 1'b0;
    end else begin
      sl_rvalid  <= sl_rvalid_d;
      sl_ack     <= sl_ack_d;
      d1_valid   <= d1_valid_d;
      cpu_rvalid <= cpu_rvalid_d;
    end
  end

  // R4 R5
  wr_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !cpu_wr) |-> (eff_addr[AW-1] ? cfg_hi_wen : cfg_lo_wen));

  // R6
  wr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sl_ack |-> $past(sl_wr));

  // R3
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sl_rvalid |-> ($past(sl_rd) && !$past(sl_wr) && !$past(sl_load)));

  // R8
  d1_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d1_valid |-> ($past(cfg_d1_en) && $past(d1_req)));

  // R8
  d1_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d1_req && !cfg_d1_en && !sl_load && !sl_wr && !sl_rd) |=> $stable(ptr_q));

  // R9
  one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && sl_wr));

  // R3
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sl_load, sl_wr, sl_rd}));
endmodule

// File: tb/test_ddc_edid_port.sv
module test_ddc_edid_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_lo_wen, cfg_hi_wen, cfg_lo_only, cfg_d1_en;
  logic       sl_load, sl_wr, sl_rd;
  logic [7:0] sl_wdata, sl_rdata, ptr_q, d1_data;
  logic       sl_rvalid, sl_ack, d1_req, d1_valid;
  logic       cpu_wr, cpu_rd, cpu_rvalid;
  logic [7:0] cpu_addr, cpu_wdata, cpu_rdata;

  int total = 0;
  int bad   = 0;
  logic [7:0] model [256];

  always #10 clk = ~clk;

  ddc_edid_port i_ddc_edid_port (
    .clk(clk), .rst_n(rst_n),
    .cfg_lo_wen(cfg_lo_wen), .cfg_hi_wen(cfg_hi_wen),
    .cfg_lo_only(cfg_lo_only), .cfg_d1_en(cfg_d1_en),
    .sl_load(sl_load), .sl_wr(sl_wr), .sl_rd(sl_rd), .sl_wdata(sl_wdata),
    .sl_rdata(sl_rdata), .sl_rvalid(sl_rvalid), .sl_ack(sl_ack), .ptr_q(ptr_q),
    .d1_req(d1_req), .d1_data(d1_data), .d1_valid(d1_valid),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic sl_load_op(input logic [7:0] v);
    @(negedge clk); sl_load = 1'b1; sl_wdata = v;
    @(negedge clk); sl_load = 1'b0;
    check("R2 pointer load", ptr_q, v);
  endtask

  task automatic sl_read_op(input logic [7:0] exp, input string tag);
    @(negedge clk); sl_rd = 1'b1;
    @(negedge clk); sl_rd = 1'b0;
    check({tag, " rvalid"}, {7'd0, sl_rvalid}, 8'd1);
    check({tag, " data"}, sl_rdata, exp);
  endtask

  task automatic sl_write_op(input logic [7:0] v);
    @(negedge clk); sl_wr = 1'b1; sl_wdata = v;
    @(negedge clk); sl_wr = 1'b0;
    check("R6 write ack", {7'd0, sl_ack}, 8'd1);
  endtask

  task automatic cpu_write_op(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_wr = 1'b0;
    model[a] = d;
  endtask

  task automatic cpu_read_chk(input logic [7:0] a, input string tag);
    @(negedge clk); cpu_rd = 1'b1; cpu_addr = a;
    @(negedge clk); cpu_rd = 1'b0;
    check({tag, " cpu rvalid"}, {7'd0, cpu_rvalid}, 8'd1);
    check(tag, cpu_rdata, model[a]);
  endtask

  task automatic t_reset;
    check("R1 ptr after reset", ptr_q, 8'h00);
    check("R1 valids after reset", {4'd0, sl_rvalid, sl_ack, d1_valid, cpu_rvalid}, 8'h00);
  endtask

  task automatic t_cpu_fill;
    cfg_lo_wen = 1'b0; cfg_hi_wen = 1'b0;
    for (int i = 0; i < 256; i++) cpu_write_op(8'(i), 8'(i * 7 + 3));
    cpu_read_chk(8'h00, "R9 cpu write lower protected");
    cpu_read_chk(8'hC3, "R9 cpu write upper protected");
  endtask

  task automatic t_seq_read;
    sl_load_op(8'h10);
    sl_read_op(model[8'h10], "R3 read 10");
    sl_read_op(model[8'h11], "R3 read 11");
    check("R3 pointer advance", ptr_q, 8'h12);
    sl_load_op(8'hFF);
    sl_read_op(model[8'hFF], "R3 read FF");
    check("R3 pointer wrap", ptr_q, 8'h00);
  endtask

  task automatic t_lower_protect;
    cfg_lo_wen = 1'b0; cfg_hi_wen = 1'b1;
    sl_load_op(8'h20);
    sl_write_op(8'h55);
    check("R6 blocked write advances", ptr_q, 8'h21);
    cpu_read_chk(8'h20, "R4 blocked lower write");
    cfg_lo_wen = 1'b1;
    sl_load_op(8'h20);
    sl_write_op(8'h55);
    model[8'h20] = 8'h55;
    cpu_read_chk(8'h20, "R4 allowed lower write");
  endtask

  task automatic t_upper_protect;
    cfg_lo_wen = 1'b1; cfg_hi_wen = 1'b0;
    sl_load_op(8'h90);
    sl_write_op(8'hAA);
    cpu_read_chk(8'h90, "R5 blocked upper write");
    cfg_hi_wen = 1'b1;
    sl_load_op(8'h90);
    sl_write_op(8'hAA);
    model[8'h90] = 8'hAA;
    sl_load_op(8'h90);
    sl_read_op(8'hAA, "R5 allowed upper write");
  endtask

  task automatic t_lower_only;
    cfg_lo_only = 1'b1;
    sl_load_op(8'h85);
    sl_read_op(model[8'h05], "R7 folded read");
    check("R7 folded pointer", ptr_q, 8'h06);
    sl_load_op(8'h7F);
    sl_read_op(model[8'h7F], "R7 read 7F");
    check("R7 wrap 7F to 00", ptr_q, 8'h00);
    cfg_lo_wen = 1'b0; cfg_hi_wen = 1'b1;
    sl_load_op(8'hC0);
    sl_write_op(8'h3C);
    cpu_read_chk(8'h40, "R7 folded write uses lower enable");
    cpu_read_chk(8'hC0, "R7 upper untouched when folded");
    cfg_lo_only = 1'b0;
  endtask

  task automatic t_ddc1;
    cfg_d1_en = 1'b0;
    sl_load_op(8'h30);
    @(negedge clk); d1_req = 1'b1;
    @(negedge clk); d1_req = 1'b0;
    check("R8 disabled no valid", {7'd0, d1_valid}, 8'd0);
    check("R8 disabled pointer held", ptr_q, 8'h30);
    cfg_d1_en = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); d1_req = 1'b1;
      @(negedge clk); d1_req = 1'b0;
      check("R8 enabled valid", {7'd0, d1_valid}, 8'd1);
      check("R8 enabled data", d1_data, model[8'(8'h30 + k)]);
    end
    check("R8 enabled pointer", ptr_q, 8'h33);
    cfg_d1_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_lo_wen = 1'b0; cfg_hi_wen = 1'b0; cfg_lo_only = 1'b0; cfg_d1_en = 1'b0;
    sl_load = 1'b0; sl_wr = 1'b0; sl_rd = 1'b0; sl_wdata = '0;
    d1_req = 1'b0; cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    check("R1 ptr in reset", ptr_q, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cpu_fill();
    t_seq_read();
    t_lower_protect();
    t_upper_protect();
    t_lower_only();
    t_ddc1();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule